// File: doc/BRIEF.md
# Registered Two-Way Bus Transceiver

This block joins two bidirectional buses, called A and B here, each `WIDTH` bits wide. Each direction of transfer has its own storage register. The A-side register samples the A bus on the rising edge of its own capture clock. The B-side register samples the B bus on the rising edge of a second, independent clock. Capture takes place on every such edge, whatever the output controls say. When the outputs are isolated, the block still records both buses.

An active-low enable and a direction bit decide which bus the block drives. Three drive modes exist: `DRV_NONE` (isolated), `DRV_A` and `DRV_B`. The mode is decoded combinationally from the enable and direction inputs, so it moves between these states in the same cycle that those inputs change. Each output path has its own select. The select picks either the live value on the opposite bus, which is a combinational pass-through, or the stored word. Each bus pin is split into a separate input, output and drive flag, and the tri-state pad sits outside the block. Both registers are cleared by an asynchronous active-low reset.

Top module: `dual_reg_xcvr`

## Requirements
- R1: While `rst_n` is low, both storage registers hold zero. After reset, the stored path of each bus outputs zero until its register captures.
- R2: When `oe_n` is 1, neither `a_drive` nor `b_drive` is asserted (mode `DRV_NONE`).
- R3: When `oe_n` is 0 and `dir` is 0, `a_drive` is 1 and `b_drive` is 0 (mode `DRV_A`).
- R4: When `oe_n` is 0 and `dir` is 1, `b_drive` is 1 and `a_drive` is 0 (mode `DRV_B`).
- R5: `a_drive` and `b_drive` are never both 1.
- R6: When `sel_ba` is 0, `a_out` equals `b_in` in the same cycle, with no register in the path.
- R7: When `sel_ba` is 1, `a_out` shows the B-side register. That register takes `b_in` on each rising edge of `clk_ba`, and the new value appears right after the edge.
- R8: When `sel_ab` is 0, `b_out` equals `a_in` in the same cycle.
- R9: When `sel_ab` is 1, `b_out` shows the A-side register. That register takes `a_in` on each rising edge of `clk_ab`.
- R10: Capture does not depend on `oe_n` or `dir`. Both registers store during isolation, and the A-side register stores `a_in` while B is being driven.
- R11: A register keeps its value across changes of its input bus when its own clock has no rising edge. An edge on one capture clock leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock of the A-side register |
| clk_ba | input | 1 | Capture clock of the B-side register |
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| oe_n | input | 1 | Active-low output enable; 1 isolates both buses |
| dir | input | 1 | 0 drives A, 1 drives B (when enabled) |
| sel_ab | input | 1 | B output source: 0 live A bus, 1 stored A word |
| sel_ba | input | 1 | A output source: 0 live B bus, 1 stored B word |
| a_in | input | WIDTH | Value seen on the A bus |
| a_out | output | WIDTH | Value to place on the A bus when driven |
| a_drive | output | 1 | Drive flag for the A bus pad |
| b_in | input | WIDTH | Value seen on the B bus |
| b_out | output | WIDTH | Value to place on the B bus when driven |
| b_drive | output | 1 | Drive flag for the B bus pad |

## Verification
The bench steps through all eight combinations of enable, direction and select, and compares the drive flags and the driven bus against a model. A swapped direction decode or a missing isolation term shows up here as the wrong bus being enabled. A design that gates capture with the enable or the direction would lose the words stored while the buses are isolated, or while B is driven, and the stored-path readback would show stale data. A design that shares one clock between both registers, or that has a live path through a register, would show a cross-register update or a one-edge lag.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    typedef enum logic [1:0] {
        DRV_NONE = 2'b00,
        DRV_A    = 2'b01,
        DRV_B    = 2'b10
    } drive_mode_e;
endpackage

// File: rtl/xcvr_dir_ctrl.sv
module xcvr_dir_ctrl
    import xcvr_pkg::*;
(
    input  logic oe_n,
    input  logic dir,
    output logic a_drive,
    output logic b_drive
);
    drive_mode_e mode;

    // mode decode
    always_comb begin
        unique casez ({oe_n, dir})
            2'b00:   mode = DRV_A;
            2'b01:   mode = DRV_B;
            2'b1?:   mode = DRV_NONE;
            default: mode = DRV_NONE;
        endcase
    end

    // drive flags from mode
    always_comb begin
        a_drive = 1'b0;
        b_drive = 1'b0;
        unique case (mode)
            DRV_A:    a_drive = 1'b1;
            DRV_B:    b_drive = 1'b1;
            DRV_NONE: ;
            default:  ;
        endcase
    end
endmodule

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux #(
    parameter int W = 8
) (
    input  logic         sel_stored,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] y
);
    always_comb y = sel_stored ? stored : live;
endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr #(
    parameter int WIDTH = 8
) (
    input  logic             clk_ab,
    input  logic             clk_ba,
    input  logic             rst_n,
    input  logic             oe_n,
    input  logic             dir,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_drive,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_drive
);
    localparam int W = WIDTH;

    logic [W-1:0] store_ab;
    logic [W-1:0] store_ba;

    xcvr_dir_ctrl u_ctrl (
        .oe_n    (oe_n),
        .dir     (dir),
        .a_drive (a_drive),
        .b_drive (b_drive)
    );

    // capture always runs; not qualified by oe_n or dir
    xcvr_capture_reg #(.W(W)) u_reg_ab (
        .clk   (clk_ab),
        .rst_n (rst_n),
        .d     (a_in),
        .q     (store_ab)
    );

    xcvr_capture_reg #(.W(W)) u_reg_ba (
        .clk   (clk_ba),
        .rst_n (rst_n),
        .d     (b_in),
        .q     (store_ba)
    );

    xcvr_path_mux #(.W(W)) u_mux_b (
        .sel_stored (sel_ab),
        .live       (a_in),
        .stored     (store_ab),
        .y          (b_out)
    );

    xcvr_path_mux #(.W(W)) u_mux_a (
        .sel_stored (sel_ba),
        .live       (b_in),
        .stored     (store_ba),
        .y          (a_out)
    );
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
    parameter int W = 8
) (
    input logic         clk_ab,
    input logic         clk_ba,
    input logic         rst_n,
    input logic         oe_n,
    input logic         dir,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic         a_drive,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic         b_drive
);
    assert_isolate_R2: assert property (@(posedge clk_ab) disable iff (!rst_n)
        oe_n |-> (!a_drive && !b_drive));

    assert_drive_a_R3: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (!oe_n && !dir) |-> (a_drive && !b_drive));

    assert_drive_b_R4: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (!oe_n && dir) |-> (b_drive && !a_drive));

    assert_one_driver_R5: assert property (@(posedge clk_ab) disable iff (!rst_n)
        $countones({a_drive, b_drive}) <= 1);

    assert_live_a_R6: assert property (@(posedge clk_ba) disable iff (!rst_n)
        !sel_ba |-> (a_out == b_in));

    assert_stored_a_R7: assert property (@(posedge clk_ba) disable iff (!rst_n)
        rst_n |=> (!sel_ba || a_out == $past(b_in)));

    assert_live_b_R8: assert property (@(posedge clk_ab) disable iff (!rst_n)
        !sel_ab |-> (b_out == a_in));

    assert_stored_b_R9: assert property (@(posedge clk_ab) disable iff (!rst_n)
        rst_n |=> (!sel_ab || b_out == $past(a_in)));
endmodule

bind dual_reg_xcvr xcvr_checker #(.W(WIDTH)) u_chk (
    .clk_ab  (clk_ab),
    .clk_ba  (clk_ba),
    .rst_n   (rst_n),
    .oe_n    (oe_n),
    .dir     (dir),
    .sel_ab  (sel_ab),
    .sel_ba  (sel_ba),
    .a_in    (a_in),
    .a_out   (a_out),
    .a_drive (a_drive),
    .b_in    (b_in),
    .b_out   (b_out),
    .b_drive (b_drive)
);

// File: tb/dual_reg_xcvr_tb_top.sv
module dual_reg_xcvr_tb_top;
    localparam int W = 8;

    logic clk = 1'b0;
    logic ab_en = 1'b0;
    logic ba_en = 1'b0;
    logic clk_ab, clk_ba;
    logic rst_n = 1'b0;
    logic oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic a_drive, b_drive;

    logic [W-1:0] ref_ab = '0;
    logic [W-1:0] ref_ba = '0;
    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;               // 125 MHz
    assign clk_ab = clk & ab_en;        // enables change only while clk is low
    assign clk_ba = clk & ba_en;

    dual_reg_xcvr #(.WIDTH(W)) dut_i (
        .clk_ab (clk_ab), .clk_ba (clk_ba), .rst_n (rst_n),
        .oe_n (oe_n), .dir (dir), .sel_ab (sel_ab), .sel_ba (sel_ba),
        .a_in (a_in), .a_out (a_out), .a_drive (a_drive),
        .b_in (b_in), .b_out (b_out), .b_drive (b_drive)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse_ab();
        @(negedge clk); ab_en = 1'b1;
        @(negedge clk); ab_en = 1'b0;
        if (rst_n) ref_ab = a_in;
        #1;
    endtask

    task automatic pulse_ba();
        @(negedge clk); ba_en = 1'b1;
        @(negedge clk); ba_en = 1'b0;
        if (rst_n) ref_ba = b_in;
        #1;
    endtask

    task automatic set_ctl(input logic o, input logic d, input logic sab, input logic sba);
        @(negedge clk);
        oe_n = o; dir = d; sel_ab = sab; sel_ba = sba;
        #1;
    endtask

    // R1: reset clears registers, even with clock edges during reset
    task automatic t_reset();
        a_in = 8'hA5; b_in = 8'h5A;
        pulse_ab(); pulse_ba();
        @(negedge clk); rst_n = 1'b1;
        a_in = 8'h11; b_in = 8'h22;
        set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R1 stored A path after reset", a_out, '0);
        set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
        chk("R1 stored B path after reset", b_out, '0);
    endtask

    // R2 R3 R4 R5 with R6..R9 on the driven bus: all eight control combos
    task automatic t_modes();
        for (int k = 0; k < 8; k++) begin
            logic o, d, s;
            logic exp_a, exp_b;
            {o, d, s} = 3'(k);
            a_in = 8'(8'h30 + k); b_in = 8'(8'hC0 + k);
            set_ctl(o, d, s, s);
            exp_a = !o && !d;
            exp_b = !o && d;
            chk(o ? "R2 a_drive" : "R3 a_drive", {7'b0, a_drive}, {7'b0, exp_a});
            chk(o ? "R2 b_drive" : "R4 b_drive", {7'b0, b_drive}, {7'b0, exp_b});
            chk("R5 single driver", {7'b0, a_drive & b_drive}, '0);
            if (exp_a) chk(s ? "R7 A bus stored" : "R6 A bus live", a_out, s ? ref_ba : b_in);
            if (exp_b) chk(s ? "R9 B bus stored" : "R8 B bus live", b_out, s ? ref_ab : a_in);
        end
    endtask

    // R6 R8: live paths follow the input in the same cycle
    task automatic t_live();
        set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++) begin
            b_in = 8'(8'h0F << k); #1;
            chk("R6 live B to A", a_out, b_in);
        end
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++) begin
            a_in = 8'(8'hF1 ^ (k * 8'h13)); #1;
            chk("R8 live A to B", b_out, a_in);
        end
    endtask

    // R7 R9 R11: stored paths and hold without an edge
    task automatic t_stored();
        set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
        b_in = 8'h9C; pulse_ba();
        chk("R7 stored after clk_ba", a_out, 8'h9C);
        b_in = 8'h01; #1;
        chk("R11 BA hold without edge", a_out, 8'h9C);
        set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
        a_in = 8'h3E; pulse_ab();
        chk("R9 stored after clk_ab", b_out, 8'h3E);
        a_in = 8'hFF; #1;
        chk("R11 AB hold without edge", b_out, 8'h3E);
        b_in = 8'h77; pulse_ab();
        set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R11 clk_ab leaves BA reg", a_out, 8'h9C);
    endtask

    // R10: capture during isolation and while B drives
    task automatic t_capture_any_mode();
        set_ctl(1'b1, 1'b0, 1'b1, 1'b1);
        a_in = 8'h5D; b_in = 8'hE2;
        pulse_ab(); pulse_ba();
        chk("R10 isolated no A drive", {7'b0, a_drive}, '0);
        set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R10 BA captured while isolated", a_out, 8'hE2);
        set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
        chk("R10 AB captured while isolated", b_out, 8'h5D);
        a_in = 8'h66; pulse_ab();
        chk("R10 AB captured while B drives", b_out, 8'h66);
        b_in = 8'h48; pulse_ba();
        set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R10 BA captured while B drives", a_out, 8'h48);
    endtask

    initial begin
        repeat (3000) @(posedge clk);
        failures++;
        $display("FAIL timeout (all) actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_modes();
        t_live();
        t_stored();
        t_capture_any_mode();
        t_modes();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule